// File: doc/BRIEF.md
# Wide Nibble-Sliced Hamming Encoder

This block protects a 128-bit word with single-error-correcting parity. It splits the word into 32 four-bit groups. Each group goes through its own (7,4) Hamming encoder. The 32 seven-bit codewords are packed side by side into a 224-bit result.

A source presents a word together with a one-cycle valid strobe. One clock later the block returns the packed codeword with its own valid. The bit positions inside each codeword follow a fixed convention that the matching decoder also uses. Its three checker equations, evaluated on a clean codeword, each give zero.

Top module: `wide_hamming_enc`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), and on the first clock after it, `out_valid` is 0 and `out_code` is all zeros.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: Lane k takes `in_data[4k+3:4k]` and places its codeword at `out_code[7k+6:7k]`, so lane 0 sits in the least significant slice.
- R4: Within a codeword, data bits B0, B1, B2 and B3 of the lane's nibble appear at codeword bits 2, 4, 5 and 6 respectively.
- R5: Codeword bit 0 equals B0^B1^B3, bit 1 equals B0^B2^B3, and bit 3 equals B1^B2^B3.
- R6: For every lane of a valid output, the checks c0^c2^c4^c6, c1^c2^c5^c6 and c3^c4^c5^c6 are all zero.
- R7: An all-zero input word produces an all-zero 224-bit output.
- R8: When `in_valid` is low at a clock edge, `out_code` keeps its previous value.
- R9: Changing a single input nibble changes only the matching 7-bit slice of the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_data` for one cycle |
| in_data | input | 128 | Word to protect, 32 nibbles |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| out_code | output | 224 | Packed 32 x 7-bit codewords |

## Verification
The block has one register stage. Every codeword and every valid therefore appears exactly one rising edge after the input was accepted. The bench changes inputs on the falling edge and samples one time unit after the following rising edge. Each check then sees the result of exactly one accepted word. Hold behaviour is checked in the same way: the bench presents a differing word with the valid low and samples after that edge. Reset clearing is checked in two places: after the initial reset, and after an asynchronous reset in the middle of the run, sampled while reset is still low.

// File: rtl/ham74_pkg.sv
package ham74_pkg;
    localparam int NIB_W = 4;
    localparam int CW_W  = 7;
    // codeword positions of data bits B0..B3
    localparam int POS_B0 = 2;
    localparam int POS_B1 = 4;
    localparam int POS_B2 = 5;
    localparam int POS_B3 = 6;
    // codeword positions of the parity bits
    localparam int POS_P0 = 0;
    localparam int POS_P1 = 1;
    localparam int POS_P2 = 3;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CW_W-1:0]  cw_t;
endpackage

// File: rtl/nib_encoder.sv
module nib_encoder
    import ham74_pkg::*;
(
    input  nib_t nib,
    output cw_t  cw
);
    always_comb begin
        cw         = '0;
        cw[POS_B0] = nib[0];
        cw[POS_B1] = nib[1];
        cw[POS_B2] = nib[2];
        cw[POS_B3] = nib[3];
        cw[POS_P0] = nib[0] ^ nib[1] ^ nib[3];
        cw[POS_P1] = nib[0] ^ nib[2] ^ nib[3];
        cw[POS_P2] = nib[1] ^ nib[2] ^ nib[3];
    end
endmodule

// File: rtl/nib_lane_array.sv
module nib_lane_array
    import ham74_pkg::*;
#(
    parameter int LANES = 32,
    localparam int IN_W  = LANES * NIB_W,
    localparam int OUT_W = LANES * CW_W
) (
    input  logic [IN_W-1:0]  word_in,
    output logic [OUT_W-1:0] code_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        cw_t lane_cw;
        nib_encoder u_enc (
            .nib (word_in[k*NIB_W +: NIB_W]),
            .cw  (lane_cw)
        );
        assign code_out[k*CW_W +: CW_W] = lane_cw;
    end
endmodule

// File: rtl/wide_hamming_enc.sv
module wide_hamming_enc
    import ham74_pkg::*;
#(
    parameter int LANES = 32,
    localparam int IN_W  = LANES * NIB_W,
    localparam int OUT_W = LANES * CW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code
);
    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] code;
    } out_state_t;

    out_state_t       st_d, st_q;
    logic [OUT_W-1:0] enc_code;

    nib_lane_array #(.LANES(LANES)) u_lanes (
        .word_in  (in_data),
        .code_out (enc_code)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.code = enc_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_code  = st_q.code;
endmodule

// File: rtl/wide_hamming_enc_chk.sv
module wide_hamming_enc_chk #(
    parameter int LANES = 32,
    localparam int IN_W  = LANES * 4,
    localparam int OUT_W = LANES * 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_code
);
    logic            checks_clean;
    logic [IN_W-1:0] recovered;

    always_comb begin
        checks_clean = 1'b1;
        recovered    = '0;
        for (int k = 0; k < LANES; k++) begin
            logic [6:0] c;
            c = out_code[k*7 +: 7];
            if ((c[0]^c[2]^c[4]^c[6]) || (c[1]^c[2]^c[5]^c[6]) || (c[3]^c[4]^c[5]^c[6]))
                checks_clean = 1'b0;
            recovered[k*4 +: 4] = {c[6], c[5], c[4], c[2]};
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_code == '0)); // R1
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_DATA_PLACE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> recovered == $past(in_data)); // R4
    AST_CHECKS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> checks_clean); // R6
    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_data == '0) |=> out_code == '0); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_code)); // R8
endmodule

bind wide_hamming_enc wide_hamming_enc_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/sim_wide_hamming_enc.sv
`timescale 1ns/1ps
module sim_wide_hamming_enc;
    localparam int LANES = 32;
    localparam int IW = LANES * 4;
    localparam int OW = LANES * 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wide_hamming_enc #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_code(out_code)
    );

    // expected codeword: data at 2,4,5,6; parity chosen so each check is even
    function automatic logic [6:0] exp_cw(input logic [3:0] b);
        logic [6:0] c;
        c = '0;
        c[2] = b[0]; c[4] = b[1]; c[5] = b[2]; c[6] = b[3];
        c[0] = c[2] ^ c[4] ^ c[6];
        c[1] = c[2] ^ c[5] ^ c[6];
        c[3] = c[4] ^ c[5] ^ c[6];
        return c;
    endfunction

    function automatic logic [OW-1:0] exp_word(input logic [IW-1:0] d);
        logic [OW-1:0] r;
        for (int k = 0; k < LANES; k++) r[k*7 +: 7] = exp_cw(d[k*4 +: 4]);
        return r;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_code(input string req, input logic [OW-1:0] exp);
        n_checks++;
        if (out_code !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, out_code, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [IW-1:0] d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check_bit("R1 valid in reset", out_valid, 1'b0);
        check_code("R1 code in reset", '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_bit("R1 valid after release", out_valid, 1'b0);
        check_code("R1 code after release", '0);
    endtask

    task automatic t_zero();
        apply(1'b1, '0);
        check_bit("R2 valid", out_valid, 1'b1);
        check_code("R7 zero word", '0);
    endtask

    task automatic t_all_nibbles();
        logic [IW-1:0] d;
        for (int k = 0; k < LANES; k++) d[k*4 +: 4] = 4'(k);
        apply(1'b1, d);
        check_code("R5 R6 all nibble values", exp_word(d));
        apply(1'b1, ~d);
        check_code("R5 inverted nibbles", exp_word(~d));
        apply(1'b1, {IW{1'b1}});
        check_code("R6 all ones", exp_word({IW{1'b1}}));
        check_bit("R6 lane0 all ones", out_code[6:0] == 7'h7F, 1'b1);
    endtask

    task automatic t_placement();
        for (int b = 0; b < 4; b++) begin
            logic [IW-1:0] d;
            d = '0;
            d[b] = 1'b1;
            apply(1'b1, d);
            check_code("R4 single data bit lane0", exp_word(d));
        end
        begin
            logic [IW-1:0] d;
            d = '0;
            d[IW-4 +: 4] = 4'h9;
            apply(1'b1, d);
            check_code("R3 top lane", exp_word(d));
            check_bit("R3 top slice", out_code[OW-7 +: 7] == 7'b1001100, 1'b1);
        end
    endtask

    task automatic t_isolation();
        logic [IW-1:0] base;
        logic [OW-1:0] ref_code;
        base = {4{32'hA5C3_1E7B}};
        apply(1'b1, base);
        ref_code = out_code;
        check_code("R3 base pattern", exp_word(base));
        for (int k = 0; k < LANES; k += 7) begin
            logic [IW-1:0] d;
            logic [OW-1:0] diff;
            d = base;
            d[k*4 +: 4] = ~d[k*4 +: 4];
            apply(1'b1, d);
            diff = out_code ^ ref_code;
            check_bit("R9 only own slice changes", (diff & ~({{(OW-7){1'b0}}, 7'h7F} << (k*7))) == '0, 1'b1);
            check_bit("R9 own slice changes", diff[k*7 +: 7] != '0, 1'b1);
        end
    endtask

    task automatic t_hold();
        logic [IW-1:0] d;
        d = {4{32'h1234_5678}};
        apply(1'b1, d);
        check_code("R3 hold preload", exp_word(d));
        apply(1'b0, ~d);
        check_bit("R2 valid drops", out_valid, 1'b0);
        check_code("R8 code holds", exp_word(d));
        apply(1'b0, '0);
        check_code("R8 code still holds", exp_word(d));
    endtask

    task automatic t_burst();
        for (int i = 0; i < 8; i++) begin
            logic [IW-1:0] d;
            d = {4{32'hDEAD_BEEF ^ (32'h1357_9BDF * i)}};
            apply(1'b1, d);
            check_bit("R2 burst valid", out_valid, 1'b1);
            check_code("R5 burst code", exp_word(d));
        end
    endtask

    task automatic t_midreset();
        apply(1'b1, {IW{1'b1}});
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check_bit("R1 async valid clear", out_valid, 1'b0);
        check_code("R1 async code clear", '0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_zero();
        t_all_nibbles();
        t_placement();
        t_isolation();
        t_hold();
        t_burst();
        t_midreset();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule